// File: doc/BRIEF.md
# Link Code Word Acknowledge Arbiter

This block runs the two-phase acknowledge handshake of twisted-pair auto-negotiation on 16-bit link code words that an upstream receiver has already decoded. While negotiation is active it tells the transmit side to keep sending the local word, and it watches incoming words. First it waits for three identical partner words, compared with the acknowledge bit ignored. It then stores that partner word and turns on the acknowledge bit in the outgoing word. After that it waits for three identical partner words that carry the acknowledge bit.

When the second phase completes, the block picks the highest technology that both sides advertise and reports its speed and duplex. If the two words share no technology, it raises a fault instead. If the receiver reports that no pulse bursts arrived, the block stops and asks for parallel detection. Negotiation begins when reset is released, on a restart command, or on loss of link, and only while the enable input is high.

Word layout used throughout: bit 14 is the acknowledge bit. The technology bits are bit 8 (100 Mb/s full duplex), bit 7 (100 Mb/s half duplex), bit 6 (10 Mb/s full duplex) and bit 5 (10 Mb/s half duplex), ranked in that order from highest to lowest.

Top module: `lcw_handshake`

## Requirements
- R1: While reset is high, every output is zero. After reset is released with the enable input high, `tx_send` is 1 after the next clock edge. Once that first start has been used, the block starts again only on a restart or a link loss.
- R2: While `neg_en` is low, the block stays idle. On the edge after `neg_en` is seen low, `tx_send`, `tx_ack`, `neg_done`, `fault` and `pd_req` are 0, and a restart has no effect.
- R3: `tx_send` is 1 in both handshake phases and 0 once the handshake has completed, faulted or handed off.
- R4: Phase one ends on the edge that samples the third consecutive received word that equals the candidate with bit 14 ignored. On that edge, `partner_word` captures that third word and `tx_ack` becomes 1. `partner_word` then holds while `tx_ack` stays 1.
- R5: A received word that differs from the candidate (bit 14 ignored) becomes the new candidate with a match count of one. The count never reaches three without a completed phase.
- R6: Phase two ends after three consecutive identical words that have bit 14 set. A word with bit 14 clear resets the phase-two count to zero.
- R7: When phase two ends, `speed_100` and `full_duplex` reflect the highest-ranked technology bit set in both the local word and the partner word, and `neg_done` becomes 1.
- R8: If the local word and the partner word share no technology bit, `fault` becomes 1 and `neg_done` stays 0. The two are never 1 together.
- R9: An `idle_timeout` pulse during phase one sets `pd_req` to 1 and clears `tx_send`. `pd_req` rises only after a timeout.
- R10: A `restart` or `link_lost` pulse while enabled restarts phase one from any state. It clears `neg_done`, `fault`, `pd_req` and `tx_ack`, and sets `tx_send`.
- R11: `tx_word` equals `local_word`, with bit 14 replaced by the current value of `tx_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| neg_en | input | 1 | Negotiation enable |
| restart | input | 1 | Restart command pulse |
| link_lost | input | 1 | Link loss pulse |
| rx_valid | input | 1 | Received word strobe |
| rx_word | input | 16 | Decoded received code word |
| local_word | input | 16 | Local advertised word |
| idle_timeout | input | 1 | No pulse bursts detected |
| partner_word | output | 16 | Stored partner ability word |
| tx_word | output | 16 | Word the transmitter should send |
| tx_send | output | 1 | Transmitter should send `tx_word` |
| tx_ack | output | 1 | Local acknowledge asserted |
| neg_done | output | 1 | Handshake complete, mode resolved |
| fault | output | 1 | No common technology |
| pd_req | output | 1 | Hand-off to parallel detection |
| speed_100 | output | 1 | Resolved speed is 100 Mb/s |
| full_duplex | output | 1 | Resolved mode is full duplex |

## Verification
Some properties are checked by assertions on every cycle:
- the idle outputs while negotiation is disabled;
- that acknowledge and completion rise only on the edge of a received word, with the acknowledge bit present for completion;
- that the partner word holds during acknowledge;
- that completion and fault never appear together;
- that the parallel-detect request follows a timeout;
- the bound on each match counter.

Other behaviour only the bench scenarios can show:
- the ordering that makes the third matching word count, and the counter reset when a word differs;
- phase-two words without the acknowledge bit being rejected;
- the restart paths;
- the ranked resolution, swept over every pair of 4-bit technology sets, including the sets with no common bit.

// File: rtl/lcw_pkg.sv
package lcw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ABILITY = 3'd1,
    ST_ACKWAIT = 3'd2,
    ST_DONE    = 3'd3,
    ST_FAULT   = 3'd4,
    ST_PDET    = 3'd5
  } lcw_state_e;

  // Technology ranking, index 0 is the highest.
  localparam int NUM_TECH = 4;
  localparam int TECH_POS [NUM_TECH] = '{8, 7, 6, 5};
  localparam logic [NUM_TECH-1:0] TECH_IS_100 = 4'b0011;
  localparam logic [NUM_TECH-1:0] TECH_IS_FDX = 4'b0101;

endpackage

// File: rtl/lcw_match_cnt.sv
module lcw_match_cnt #(
  parameter int W        = 16,
  parameter int N        = 3,
  parameter int ACK_POS  = 14,
  parameter bit MASK_ACK = 1'b1,
  parameter bit NEED_ACK = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         valid,
  input  logic [W-1:0] word,
  output logic         hit
);
  localparam int CW = $clog2(N + 1);
  localparam logic [W-1:0] ACK_ONE  = W'(1) << ACK_POS;
  localparam logic [W-1:0] CMP_MASK = MASK_ACK ? ~ACK_ONE : {W{1'b1}};

  logic [W-1:0]  cand_q;
  logic [CW-1:0] cnt_q;
  logic          eligible;
  logic          same;

  always_comb begin
    eligible = !NEED_ACK || word[ACK_POS];
    same     = (cnt_q != '0) && (((word ^ cand_q) & CMP_MASK) == '0);
    hit      = valid && eligible && ((same && cnt_q == CW'(N - 1)) || (N == 1));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      cand_q <= '0;
    end else if (valid) begin
      if (!eligible) begin
        cnt_q <= '0;
      end else if (hit) begin
        cnt_q <= '0;
      end else if (same) begin
        cnt_q <= cnt_q + CW'(1);
      end else begin
        cnt_q  <= CW'(1);
        cand_q <= word;
      end
    end
  end

  // R5 / R6: the count resets on a completed match, so it stays below N.
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(N))
    else $error("match count reached its limit");

endmodule

// File: rtl/lcw_resolve.sv
module lcw_resolve
  import lcw_pkg::*;
(
  input  logic [NUM_TECH-1:0] common,
  output logic                found,
  output logic                spd100,
  output logic                fdx
);
  // Scan from the lowest rank to the highest so that the highest common one wins.
  always_comb begin
    found  = 1'b0;
    spd100 = 1'b0;
    fdx    = 1'b0;
    for (int i = NUM_TECH - 1; i >= 0; i--) begin
      if (common[i]) begin
        found  = 1'b1;
        spd100 = TECH_IS_100[i];
        fdx    = TECH_IS_FDX[i];
      end
    end
  end

endmodule

// File: rtl/lcw_handshake.sv
module lcw_handshake
  import lcw_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int ACK_POS = 14,
  parameter int MATCH_N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              neg_en,
  input  logic              restart,
  input  logic              link_lost,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] local_word,
  input  logic              idle_timeout,
  output logic [WORD_W-1:0] partner_word,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_send,
  output logic              tx_ack,
  output logic              neg_done,
  output logic              fault,
  output logic              pd_req,
  output logic              speed_100,
  output logic              full_duplex
);
  localparam logic [WORD_W-1:0] ACK_ONE = WORD_W'(1) << ACK_POS;

  lcw_state_e state_q, state_d;
  logic boot_q;
  logic start_evt;
  logic hit_ab, hit_ack;
  logic clr_ab, clr_ack;
  logic [NUM_TECH-1:0] common;
  logic res_found, res_100, res_fdx;

  assign start_evt = neg_en && (boot_q || restart || link_lost);

  always_comb begin
    state_d = state_q;
    if (!neg_en) begin
      state_d = ST_IDLE;
    end else if (start_evt) begin
      state_d = ST_ABILITY;
    end else begin
      unique case (state_q)
        ST_ABILITY: begin
          if (idle_timeout)  state_d = ST_PDET;
          else if (hit_ab)   state_d = ST_ACKWAIT;
        end
        ST_ACKWAIT: begin
          if (hit_ack)       state_d = res_found ? ST_DONE : ST_FAULT;
        end
        default: state_d = state_q;
      endcase
    end
  end

  assign clr_ab  = start_evt || (state_d != ST_ABILITY);
  assign clr_ack = start_evt || (state_d != ST_ACKWAIT);

  lcw_match_cnt #(
    .W(WORD_W), .N(MATCH_N), .ACK_POS(ACK_POS), .MASK_ACK(1'b1), .NEED_ACK(1'b0)
  ) u_match_ability (
    .clk(clk), .rst(rst), .clear(clr_ab),
    .valid(rx_valid && state_q == ST_ABILITY), .word(rx_word), .hit(hit_ab)
  );

  lcw_match_cnt #(
    .W(WORD_W), .N(MATCH_N), .ACK_POS(ACK_POS), .MASK_ACK(1'b0), .NEED_ACK(1'b1)
  ) u_match_ack (
    .clk(clk), .rst(rst), .clear(clr_ack),
    .valid(rx_valid && state_q == ST_ACKWAIT), .word(rx_word), .hit(hit_ack)
  );

  for (genvar g = 0; g < NUM_TECH; g++) begin : g_common
    assign common[g] = local_word[TECH_POS[g]] & partner_word[TECH_POS[g]];
  end

  lcw_resolve u_resolve (
    .common(common), .found(res_found), .spd100(res_100), .fdx(res_fdx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      boot_q       <= 1'b1;
      partner_word <= '0;
      tx_word      <= '0;
      tx_send      <= 1'b0;
      tx_ack       <= 1'b0;
      neg_done     <= 1'b0;
      fault        <= 1'b0;
      pd_req       <= 1'b0;
      speed_100    <= 1'b0;
      full_duplex  <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (state_d == ST_ABILITY) boot_q <= 1'b0;
      tx_send  <= (state_d == ST_ABILITY) || (state_d == ST_ACKWAIT);
      tx_ack   <= (state_d == ST_ACKWAIT);
      neg_done <= (state_d == ST_DONE);
      fault    <= (state_d == ST_FAULT);
      pd_req   <= (state_d == ST_PDET);
      tx_word  <= (state_d == ST_ACKWAIT) ? (local_word | ACK_ONE) : (local_word & ~ACK_ONE);
      if (state_q == ST_ABILITY && state_d == ST_ACKWAIT) partner_word <= rx_word;
      if (state_q == ST_ACKWAIT && state_d == ST_DONE) begin
        speed_100   <= res_100;
        full_duplex <= res_fdx;
      end else if (state_d != ST_DONE) begin
        speed_100   <= 1'b0;
        full_duplex <= 1'b0;
      end
    end
  end

  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    !neg_en |=> (!tx_send && !tx_ack && !neg_done && !pd_req && !fault))
    else $error("outputs active while disabled");

  p_ack_needs_word_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ack) |-> $past(rx_valid))
    else $error("acknowledge rose without a received word");

  p_partner_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_ack && $past(tx_ack)) |-> $stable(partner_word))
    else $error("partner word changed during acknowledge");

  p_done_needs_ack_word_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(neg_done) |-> ($past(rx_valid) && $past(rx_word[ACK_POS])))
    else $error("completion without an acknowledged word");

  p_done_excl_fault_r8: assert property (@(posedge clk) disable iff (rst)
    !(neg_done && fault))
    else $error("done and fault together");

  p_pd_needs_timeout_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_req) |-> $past(idle_timeout))
    else $error("parallel detect without timeout");

endmodule

// File: tb/lcw_handshake_tb.sv
`timescale 1ns/1ps
module lcw_handshake_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst, neg_en, restart, link_lost, rx_valid, idle_timeout;
  logic [W-1:0] rx_word, local_word;
  logic [W-1:0] partner_word, tx_word;
  logic tx_send, tx_ack, neg_done, fault, pd_req, speed_100, full_duplex;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lcw_handshake dut_i (
    .clk(clk), .rst(rst), .neg_en(neg_en), .restart(restart), .link_lost(link_lost),
    .rx_valid(rx_valid), .rx_word(rx_word), .local_word(local_word),
    .idle_timeout(idle_timeout), .partner_word(partner_word), .tx_word(tx_word),
    .tx_send(tx_send), .tx_ack(tx_ack), .neg_done(neg_done), .fault(fault),
    .pd_req(pd_req), .speed_100(speed_100), .full_duplex(full_duplex)
  );

  function automatic logic [W-1:0] mk(input logic [3:0] tech, input logic ack);
    return {1'b0, ack, 5'b0, tech, 5'b00001};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] w);
    @(negedge clk); rx_valid = 1'b1; rx_word = w;
    @(negedge clk); rx_valid = 1'b0; rx_word = '0;
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] wa, wb;
    rst = 1'b1; neg_en = 1'b0; restart = 1'b0; link_lost = 1'b0;
    rx_valid = 1'b0; idle_timeout = 1'b0; rx_word = '0; local_word = mk(4'b1111, 1'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {tx_send, tx_ack, neg_done, fault, pd_req, speed_100, full_duplex}, 0);
    check("R1 reset partner", partner_word, 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    pulse_restart();
    @(negedge clk);
    check("R2 disabled restart ignored", tx_send, 0);
    neg_en = 1'b1;
    @(negedge clk);
    check("R1 start after reset", tx_send, 1);
    check("R11 tx word no ack", tx_word, mk(4'b1111, 1'b0));

    // R4: ack bit ignored in phase one; third word latched
    wa = mk(4'b1010, 1'b0);
    send(wa); send(wa | 16'h4000);
    check("R4 no ack after two", tx_ack, 0);
    send(wa);
    check("R4 ack after third", tx_ack, 1);
    check("R4 partner latched", partner_word, wa);
    check("R3 send in phase two", tx_send, 1);
    check("R11 tx word with ack", tx_word, mk(4'b1111, 1'b1));

    // R6: word without ack resets count
    send(wa | 16'h4000); send(wa | 16'h4000); send(wa);
    check("R6 no done with plain word", neg_done, 0);
    send(wa | 16'h4000); send(wa | 16'h4000);
    check("R6 no done after two", neg_done, 0);
    send(wa | 16'h4000);
    check("R6 done after third", neg_done, 1);
    check("R7 mode 100 full", {speed_100, full_duplex}, 2'b11);
    check("R3 send off when done", tx_send, 0);

    // R10 link loss
    @(negedge clk); link_lost = 1'b1;
    @(negedge clk); link_lost = 1'b0;
    check("R10 link loss restarts", {tx_send, tx_ack, neg_done}, 3'b100);

    // R5 differing word resets count
    wb = mk(4'b0110, 1'b0);
    send(wa); send(wa); send(wb); send(wb);
    check("R5 count restarted", tx_ack, 0);
    send(wb);
    check("R5 new candidate wins", tx_ack, 1);
    check("R5 partner is new word", partner_word, wb);

    // R9 timeout
    pulse_restart();
    check("R10 restart clears ack", {tx_send, tx_ack}, 2'b10);
    @(negedge clk); idle_timeout = 1'b1;
    @(negedge clk); idle_timeout = 1'b0;
    check("R9 parallel detect", {pd_req, tx_send}, 2'b10);

    // R2 disable, R1 no automatic start afterwards
    @(negedge clk); neg_en = 1'b0;
    @(negedge clk);
    check("R2 disabled clears", {pd_req, tx_send}, 2'b00);
    neg_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 no start without event", tx_send, 0);
    pulse_restart();
    check("R10 restart from idle", tx_send, 1);

    // R7 / R8 sweep over every pair of technology sets
    for (int l = 0; l < 16; l++) begin
      for (int p = 0; p < 16; p++) begin
        logic [3:0] cm;
        logic found, e100, efd;
        @(negedge clk); local_word = mk(4'(l), 1'b0);
        pulse_restart();
        send(mk(4'(p), 1'b0)); send(mk(4'(p), 1'b0)); send(mk(4'(p), 1'b0));
        check("R4 sweep ack", tx_ack, 1);
        send(mk(4'(p), 1'b1)); send(mk(4'(p), 1'b1)); send(mk(4'(p), 1'b1));
        cm = 4'(l) & 4'(p);
        found = (cm != 0);
        e100 = cm[3] | cm[2];
        efd  = cm[3] | (!cm[2] & cm[1]);
        if (found) begin
          check("R7 sweep resolve", {neg_done, fault, speed_100, full_duplex}, {2'b10, e100, efd});
        end else begin
          check("R8 sweep fault", {neg_done, fault, speed_100, full_duplex}, 4'b0100);
        end
      end
    end
    finish_run();
  end

endmodule